// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Maintenance Commands

This block holds a small, fully associative table of address translations that software manages directly. Each slot maps two neighbouring virtual pages, even and odd, onto two independent physical frames. It also records an address-space tag, a page-size mask and a shared global flag. Software loads staging values for the virtual tag, the two frame descriptors, the size mask, an index and a random slot number. It then issues one of four commands: store at an index, store at the random slot, search, or load back.

A search compares the staged virtual tag and address-space tag against every slot in the same cycle. It returns the lowest slot that matches. If nothing matches, it returns a miss flag together with the staged index. A load-back copies a slot out in the same layout that software uses to write it. Turning loads and stores into physical addresses is left to other logic, and so is choosing the random slot.

Top module: `tlbx_top`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, `done` is 0 and `index_out`, `hi_out`, `lo0_out`, `lo1_out` and `mask_out` are 0. Reset clears every slot, so a load-back of any slot right after reset returns all zeros.
- R2: Command code 0 (store at index) writes slot `index_in % NE`. Command code 3 (load back) reads slot `index_in % NE`. An index of NE or more therefore wraps.
- R3: A store keeps `hi_in[31:13]` as the virtual tag, with bits 12:0 forced to zero, and `hi_in[7:0]` as the address-space tag. Bits 12:8 of `hi_in` are discarded.
- R4: The stored global flag is `lo0_in[0] & lo1_in[0]`. A load-back returns that flag in bit 0 of both `lo0_out` and `lo1_out`.
- R5: Command code 1 (store at random slot) writes slot `random_in % NE` and ignores `index_in`.
- R6: Command code 2 (search) finds a slot when both of the following hold. First, the slot's global flag is set, or its address-space tag equals `hi_in[7:0]`. Second, the slot's virtual tag and `hi_in` agree on every bit outside the compare mask. On a hit, `index_out` becomes the slot number with bit 31 clear.
- R7: The compare mask is the slot's stored page mask ORed with `32'h1FFF`. Setting page-mask bits widens the address range that one slot matches.
- R8: When several slots match, the search reports the lowest slot number.
- R9: On a search miss, `index_out` becomes `index_in` with bit 31 set. Only a search changes `index_out`.
- R10: Each `start` pulse produces exactly one `done` pulse on the next cycle. `done` is 0 on every other cycle.
- R11: A load-back sets `hi_out = tag | asid` and `mask_out` to the stored mask. Each frame output is laid out as {frame number in bits 31:6, cache attribute in 5:3, dirty in 2, valid in 1, global in 0}. The load-back outputs change only on a load-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, one cycle |
| op | input | 2 | Command: 0 store at index, 1 store at random slot, 2 search, 3 load back |
| hi_in | input | 32 | Staged virtual tag and address-space tag |
| lo0_in | input | 32 | Staged even-page frame descriptor |
| lo1_in | input | 32 | Staged odd-page frame descriptor |
| mask_in | input | 32 | Staged page-size mask |
| index_in | input | 32 | Staged slot index |
| random_in | input | 32 | Slot number for a store at the random slot |
| done | output | 1 | Command-complete pulse |
| hi_out | output | 32 | Load-back tag and address-space tag |
| lo0_out | output | 32 | Load-back even-page descriptor |
| lo1_out | output | 32 | Load-back odd-page descriptor |
| mask_out | output | 32 | Load-back page mask |
| index_out | output | 32 | Search result or miss flag |

## Verification
The checker assumes that `start` is a single-cycle strobe with at least one idle cycle between commands. Under that assumption every `done` can be tied to one earlier `start`. It also assumes `op` is stable while `start` is high. The bench drives each command for exactly one cycle and then idles for a cycle, so it stays within these assumptions. It keeps `random_in` in range and uses `index_in` values beyond the slot count only to exercise the wrap.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned PAIR_LSB = 13;
  localparam int unsigned FRAME_LSB = 6;
  localparam logic [WORD_W-1:0] PAIR_MASK = WORD_W'((1 << PAIR_LSB) - 1);
  localparam logic [WORD_W-1:0] MISS_FLAG = {1'b1, {(WORD_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CMD_STORE_IDX  = 2'd0,
    CMD_STORE_RND  = 2'd1,
    CMD_SEARCH     = 2'd2,
    CMD_LOAD_BACK  = 2'd3
  } cmd_e;

  typedef struct packed {
    logic [WORD_W-1:FRAME_LSB] frame;
    logic [2:0]                attr;
    logic                      dirty;
    logic                      valid;
  } half_t;

  typedef struct packed {
    logic [WORD_W-1:0] tag;
    logic [ASID_W-1:0] asid;
    logic [WORD_W-1:0] pmask;
    logic              glob;
    half_t             even;
    half_t             odd;
  } slot_t;

  function automatic slot_t build_slot(input logic [WORD_W-1:0] hi,
                                       input logic [WORD_W-1:0] lo0,
                                       input logic [WORD_W-1:0] lo1,
                                       input logic [WORD_W-1:0] pm);
    slot_t s;
    s.tag   = hi & ~PAIR_MASK;
    s.asid  = hi[ASID_W-1:0];
    s.pmask = pm;
    s.glob  = lo0[0] & lo1[0];
    s.even  = lo0[WORD_W-1:1];
    s.odd   = lo1[WORD_W-1:1];
    return s;
  endfunction
endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
  import tlbx_pkg::*;
#(
  parameter int unsigned NE = 16,
  localparam int unsigned IDX_W = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  slot_t            wslot,
  output slot_t            slots [NE]
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NE; i++) slots[i] <= '0;
    end else if (we) begin
      slots[widx] <= wslot;
    end
  end
endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
#(
  parameter int unsigned NE = 16,
  localparam int unsigned IDX_W = (NE > 1) ? $clog2(NE) : 1
) (
  input  slot_t             slots [NE],
  input  logic [WORD_W-1:0] key,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [NE-1:0] vec;

  for (genvar g = 0; g < NE; g++) begin : g_cmp
    logic [WORD_W-1:0] cmask;
    logic              tag_eq, asid_ok;
    assign cmask   = slots[g].pmask | PAIR_MASK;
    assign tag_eq  = (slots[g].tag & ~cmask) == (key & ~cmask);
    assign asid_ok = slots[g].glob || (slots[g].asid == key[ASID_W-1:0]);
    assign vec[g]  = tag_eq && asid_ok;
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NE - 1; i >= 0; i--) begin
      if (vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |vec;
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
  import tlbx_pkg::*;
#(
  parameter int unsigned NE = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [31:0] hi_in,
  input  logic [31:0] lo0_in,
  input  logic [31:0] lo1_in,
  input  logic [31:0] mask_in,
  input  logic [31:0] index_in,
  input  logic [31:0] random_in,
  output logic        done,
  output logic [31:0] hi_out,
  output logic [31:0] lo0_out,
  output logic [31:0] lo1_out,
  output logic [31:0] mask_out,
  output logic [31:0] index_out
);
  localparam int unsigned IDX_W = (NE > 1) ? $clog2(NE) : 1;

  cmd_e             cmd;
  slot_t            slots [NE];
  slot_t            wslot;
  slot_t            rslot;
  logic [IDX_W-1:0] idx_sel, rnd_sel, widx;
  logic             we, hit;
  logic [IDX_W-1:0] hit_idx;

  assign cmd     = cmd_e'(op);
  assign idx_sel = IDX_W'(index_in % WORD_W'(NE));
  assign rnd_sel = IDX_W'(random_in % WORD_W'(NE));
  assign we      = start && (cmd == CMD_STORE_IDX || cmd == CMD_STORE_RND);
  assign widx    = (cmd == CMD_STORE_RND) ? rnd_sel : idx_sel;
  assign wslot   = build_slot(hi_in, lo0_in, lo1_in, mask_in);
  assign rslot   = slots[idx_sel];

  tlbx_store #(.NE(NE)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (we),
    .widx  (widx),
    .wslot (wslot),
    .slots (slots)
  );

  tlbx_match #(.NE(NE)) u_match (
    .slots   (slots),
    .key     (hi_in),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      hi_out    <= '0;
      lo0_out   <= '0;
      lo1_out   <= '0;
      mask_out  <= '0;
      index_out <= '0;
    end else begin
      done <= start;
      if (start && cmd == CMD_SEARCH) begin
        index_out <= hit ? WORD_W'(hit_idx) : (index_in | MISS_FLAG);
      end
      if (start && cmd == CMD_LOAD_BACK) begin
        hi_out   <= rslot.tag | WORD_W'(rslot.asid);
        mask_out <= rslot.pmask;
        lo0_out  <= {rslot.even, rslot.glob};
        lo1_out  <= {rslot.odd, rslot.glob};
      end
    end
  end
endmodule

// File: rtl/tlbx_checks.sv
module tlbx_checks #(
  parameter int unsigned NE = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [1:0]  op,
  input logic        done,
  input logic [31:0] hi_out,
  input logic [31:0] lo0_out,
  input logic [31:0] lo1_out,
  input logic [31:0] index_out
);
  localparam int unsigned IDX_W = (NE > 1) ? $clog2(NE) : 1;

  // R1: outputs clear on the cycle after reset
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!done && index_out == '0 && hi_out == '0));

  // R10: a strobe gives a done pulse on the next cycle
  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  // R10: no done without a preceding strobe
  a_r10_no_stray_done: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  // R9: only a search may change the index result
  a_r9_index_held: assert property (@(posedge clk) disable iff (rst)
    !(start && op == 2'd2) |=> $stable(index_out));

  // R6: a search result is either a miss flag or a slot number in range
  a_r6_hit_in_range: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'd2) |=> (index_out[31] || index_out[30:IDX_W] == '0));

  // R11: load-back outputs change only on a load-back
  a_r11_readback_held: assert property (@(posedge clk) disable iff (rst)
    !(start && op == 2'd3) |=> ($stable(hi_out) && $stable(lo0_out) && $stable(lo1_out)));

  // R4: both load-back halves carry the same global flag
  a_r4_glob_shared: assert property (@(posedge clk) disable iff (rst)
    (start && op == 2'd3) |=> (lo0_out[0] == lo1_out[0]));
endmodule

bind tlbx_top tlbx_checks #(.NE(NE)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .op        (op),
  .done      (done),
  .hi_out    (hi_out),
  .lo0_out   (lo0_out),
  .lo1_out   (lo1_out),
  .index_out (index_out)
);

// File: tb/tlbx_top_bench.sv
module tlbx_top_bench;
  localparam int NE = 16;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [31:0] hi_in = '0, lo0_in = '0, lo1_in = '0, mask_in = '0;
  logic [31:0] index_in = '0, random_in = '0;
  logic        done;
  logic [31:0] hi_out, lo0_out, lo1_out, mask_out, index_out;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlbx_top #(.NE(NE)) u_tlbx_top (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .hi_in(hi_in), .lo0_in(lo0_in), .lo1_in(lo1_in), .mask_in(mask_in),
    .index_in(index_in), .random_in(random_in),
    .done(done), .hi_out(hi_out), .lo0_out(lo0_out), .lo1_out(lo1_out),
    .mask_out(mask_out), .index_out(index_out)
  );

  typedef struct {
    int          kind;   // 0 store, 1 load back, 2 search
    logic [31:0] hi, lo0, lo1, pm, idx;
    string       req;
  } exp_t;

  exp_t        sb[$];
  int          n_run = 0, n_fail = 0, n_cmd = 0, n_done = 0;
  bit          finished = 0;

  logic [31:0] m_tag [NE], m_pm [NE], m_lo0 [NE], m_lo1 [NE];
  logic [7:0]  m_asid [NE];
  logic        m_g [NE];

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input logic [31:0] hi, input logic [31:0] l0,
                       input logic [31:0] l1, input logic [31:0] pm,
                       input logic [31:0] ix, input logic [31:0] rn, input string req);
    exp_t e;
    int   s;
    e = '{kind: 0, hi: '0, lo0: '0, lo1: '0, pm: '0, idx: '0, req: req};
    if (c == 2'd0 || c == 2'd1) begin
      s = (c == 2'd0) ? int'(ix % NE) : int'(rn % NE);
      m_tag[s] = hi & ~32'h1FFF; m_asid[s] = hi[7:0]; m_pm[s] = pm;
      m_g[s] = l0[0] & l1[0];
      m_lo0[s] = {l0[31:1], 1'b0}; m_lo1[s] = {l1[31:1], 1'b0};
    end else if (c == 2'd3) begin
      s = int'(ix % NE);
      e.kind = 1;
      e.hi = m_tag[s] | {24'h0, m_asid[s]};
      e.pm = m_pm[s];
      e.lo0 = m_lo0[s] | {31'h0, m_g[s]};
      e.lo1 = m_lo1[s] | {31'h0, m_g[s]};
    end else begin
      e.kind = 2;
      e.idx = ix | 32'h8000_0000;
      for (int i = NE - 1; i >= 0; i--) begin
        logic [31:0] cm;
        cm = m_pm[i] | 32'h1FFF;
        if ((m_g[i] || m_asid[i] == hi[7:0]) && ((m_tag[i] & ~cm) == (hi & ~cm)))
          e.idx = i;
      end
    end
    sb.push_back(e);
    @(negedge clk);
    op = c; hi_in = hi; lo0_in = l0; lo1_in = l1; mask_in = pm;
    index_in = ix; random_in = rn; start = 1'b1;
    n_cmd++;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      exp_t e;
      n_done++;
      if (sb.size() == 0) begin
        check(0, "R10 unexpected done", 32'h1, 32'h0);
      end else begin
        e = sb.pop_front();
        if (e.kind == 1) begin
          check(hi_out == e.hi, {e.req, " hi"}, hi_out, e.hi);
          check(lo0_out == e.lo0, {e.req, " lo0"}, lo0_out, e.lo0);
          check(lo1_out == e.lo1, {e.req, " lo1"}, lo1_out, e.lo1);
          check(mask_out == e.pm, {e.req, " mask"}, mask_out, e.pm);
        end else if (e.kind == 2) begin
          check(index_out == e.idx, {e.req, " index"}, index_out, e.idx);
        end
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin
      m_tag[i] = '0; m_pm[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0; m_asid[i] = '0; m_g[i] = 0;
    end
    repeat (3) @(negedge clk);
    check(done == 0 && index_out == 0 && hi_out == 0 && lo0_out == 0 && mask_out == 0,
          "R1 reset outputs", index_out | hi_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && index_out == 0, "R1 after reset", index_out, 32'h0);

    // R1: cleared slot reads back as zero
    issue(2'd3, 0, 0, 0, 0, 32'd5, 0, "R1 cleared slot");
    // R2 R3 R4 R11: store at index 2, G not both set, then read
    issue(2'd0, 32'h1234_5FAB, 32'h0ABC_DE1F, 32'h0001_2316, 32'h0, 32'd2, 0, "R2 store");
    issue(2'd3, 0, 0, 0, 0, 32'd2, 0, "R3 R4 R11 readback slot 2");
    // R2: wrapped index 19 -> slot 3
    issue(2'd0, 32'h7700_0011, 32'h0000_0047, 32'h0000_0083, 32'h0, 32'd19, 0, "R2 wrap store");
    issue(2'd3, 0, 0, 0, 0, 32'd3, 0, "R2 wrap readback");
    // R5: store at random slot 7 with a different index staged, global pair
    issue(2'd1, 32'h5000_0022, 32'h0000_1003, 32'h0000_2003, 32'h0, 32'd1, 32'd7, "R5 random store");
    issue(2'd3, 0, 0, 0, 0, 32'd7, 0, "R5 R4 readback slot 7");
    issue(2'd3, 0, 0, 0, 0, 32'd1, 0, "R5 index slot untouched");
    // R6: hit on ASID match with junk in low bits
    issue(2'd2, 32'h1234_5FAB, 0, 0, 0, 32'd9, 0, "R6 asid hit");
    // R9: ASID mismatch, no global -> miss keeps staged index
    issue(2'd2, 32'h1234_4001, 0, 0, 0, 32'd5, 0, "R9 miss");
    // R6 R4: global slot 7 hits any ASID
    issue(2'd2, 32'h5000_00EE, 0, 0, 0, 32'd0, 0, "R6 global hit");
    // R7: larger page on slot 9
    issue(2'd0, 32'h4000_0001, 32'h0000_0002, 32'h0000_0002, 32'h0001_E000, 32'd9, 0, "R7 store");
    issue(2'd2, 32'h4001_6001, 0, 0, 0, 32'd0, 0, "R7 masked hit");
    issue(2'd2, 32'h4002_0001, 0, 0, 0, 32'd4, 0, "R7 outside mask miss");
    // R8: duplicates, lowest wins
    issue(2'd0, 32'h4000_0001, 32'h0000_0002, 32'h0000_0002, 32'h0001_E000, 32'd12, 0, "R8 store 12");
    issue(2'd2, 32'h4000_8001, 0, 0, 0, 32'd0, 0, "R8 lowest of 9 and 12");
    issue(2'd0, 32'h4000_0001, 32'h0000_0002, 32'h0000_0002, 32'h0001_E000, 32'd4, 0, "R8 store 4");
    issue(2'd2, 32'h4000_8001, 0, 0, 0, 32'd0, 0, "R8 lowest of 4 9 12");
    issue(2'd3, 0, 0, 0, 0, 32'd9, 0, "R11 mask readback");

    repeat (4) @(negedge clk);
    check(sb.size() == 0 && n_done == n_cmd, "R10 one done per command", n_done, n_cmd);
    summary();
  end
endmodule